// File: doc/BRIEF.md
# DRAM Burst Refresh and Self-Refresh Sequencer

This block sits between a memory access arbiter and the strobe and row-address pins of an asynchronous DRAM. When asked to put the memory into self-refresh, it first takes the pins away from the arbiter by dropping the grant. It then runs a burst of back-to-back refresh cycles and enters self-refresh. When the exit request arrives, it releases self-refresh and runs a second burst before handing the pins back. The refresh flavour is chosen by a static mode input. In one mode CAS is strobed ahead of RAS and the memory picks the row. In the other only RAS is pulsed, and an internal row counter drives the row address.

Two timing windows are measured in timer ticks, whose rate is set by a parameter. The first runs from the RAS fall of the first refresh cycle before entry to the RAS fall that starts self-refresh. The second runs from the RAS rise that ends self-refresh to the RAS fall of the last refresh cycle after exit. If a window runs out before its burst is done, a sticky error flag goes high. Self-refresh is held for a minimum tick count, even if exit is asked for earlier. The arbiter may abort a burst. The abort only takes effect once the refresh cycle in progress has finished.

Top module: `dram_rfsh_seq`

## Requirements
- R1: After reset, ras_n_o and cas_n_o are high, row_o is 0 and win_err_o is 0.
- R2: rw_gnt_o equals rw_req_i only while the sequencer is idle and sr_enter_i is low. It is 0 in the cycle that sr_enter_i is high, for the whole of both bursts and of self-refresh, and it returns once the post-exit burst completes.
- R3: Each burst, before entry and after exit, is exactly ROWS (512) RAS pulses, each RAS_CLKS (2) clocks low.
- R4: With ras_only_mode_i = 0, cas_n_o is low in the clock before every refresh RAS fall and stays low while RAS is low.
- R5: With ras_only_mode_i = 1, cas_n_o stays high during refresh pulses. row_o is stable while RAS is low and steps through 0 to ROWS-1 in ascending order, one value per pulse, wrapping from ROWS-1 to 0. row_o never advances in the other mode.
- R6: After the pre-entry burst, cas_n_o falls one clock ahead of ras_n_o, and both stay low. RAS stays low for at least SR_MIN_US worth of ticks, even when sr_exit_i arrives earlier.
- R7: A latched sr_exit_i releases self-refresh at the first edge where the minimum hold is met. RAS and CAS rise together, and the post-exit burst follows.
- R8: win_err_o goes high, and stays high until reset, if WINDOW_US worth of ticks elapse inside either window before that window closes.
- R9: abort_i during a burst lets the refresh pulse in progress finish at full width. After that pulse no further RAS fall occurs, self-refresh is not entered and the grant returns. abort_i while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick, one clock wide, rate TICK_HZ |
| ras_only_mode_i | input | 1 | 1 = RAS-only refresh with internal row, 0 = CAS-before-RAS |
| rw_req_i | input | 1 | Arbiter request for the memory pins |
| sr_enter_i | input | 1 | Request to enter self-refresh |
| sr_exit_i | input | 1 | Request to leave self-refresh (latched) |
| abort_i | input | 1 | Arbiter abort of a running burst |
| rw_gnt_o | output | 1 | Grant of the memory pins to the arbiter |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| row_o | output | ROW_W (9) | Row address for RAS-only refresh |
| win_err_o | output | 1 | Sticky window overrun flag |

## Verification
A pending read/write request and a self-refresh entry request can land in the same idle cycle. The bench raises rw_req_i and sr_enter_i together and checks that the grant is low in that very cycle, so entry wins. It also checks that the grant stays low through the burst and self-refresh that follow, and that it comes back only after the post-exit burst. An abort that lands while a RAS pulse is low is judged by measuring the width of that pulse and by counting that no later pulse starts.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_BURST,
    ST_SR_LEAD,
    ST_SR_HOLD,
    ST_POST_BURST
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LEAD,
    PH_ACT,
    PH_PRE
  } cyc_phase_t;

  // Microseconds to timer ticks for a tick rate in Hz.
  function automatic int unsigned us_to_ticks(input int unsigned tick_hz,
                                              input int unsigned us);
    return ((tick_hz / 1000) * us) / 1000;
  endfunction

  // Increment with wrap at modn.
  function automatic int unsigned wrap_inc(input int unsigned v,
                                           input int unsigned modn);
    return (v + 1 == modn) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/rfsh_tick_timer.sv
module rfsh_tick_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic reached_o
);
  localparam int unsigned W = $clog2(LIMIT + 1) + 1;
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt <= '0;
    else if (!run_i)       cnt <= '0;
    else if (tick_i && cnt < LIM) cnt <= cnt + 1'b1;
  end

  assign reached_o = (cnt >= LIM);

  AST_TIMER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && reached_o) |=> reached_o); // R8

endmodule

// File: rtl/rfsh_cycle_gen.sv
module rfsh_cycle_gen import dram_rfsh_pkg::*; #(
  parameter int unsigned LEAD_CLKS = 1,
  parameter int unsigned RAS_CLKS  = 2,
  parameter int unsigned PRE_CLKS  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ras_only_i,
  output logic ras_low_o,
  output logic cas_low_o,
  output logic act_first_o,
  output logic done_o,
  output logic idle_o
);
  localparam int unsigned M1   = (LEAD_CLKS > RAS_CLKS) ? LEAD_CLKS : RAS_CLKS;
  localparam int unsigned MAXC = (M1 > PRE_CLKS) ? M1 : PRE_CLKS;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LEAD_LD = CW'(LEAD_CLKS - 1);
  localparam logic [CW-1:0] RAS_LD  = CW'(RAS_CLKS - 1);
  localparam logic [CW-1:0] PRE_LD  = CW'(PRE_CLKS - 1);

  cyc_phase_t    phase;
  logic [CW-1:0] cnt;
  logic          ro_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      ro_q  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (start_i) begin
          ro_q <= ras_only_i;
          if (ras_only_i) begin phase <= PH_ACT;  cnt <= RAS_LD;  end
          else            begin phase <= PH_LEAD; cnt <= LEAD_LD; end
        end
        PH_LEAD: if (cnt == '0) begin phase <= PH_ACT; cnt <= RAS_LD; end
                 else cnt <= cnt - 1'b1;
        PH_ACT:  if (cnt == '0) begin phase <= PH_PRE; cnt <= PRE_LD; end
                 else cnt <= cnt - 1'b1;
        default: if (cnt == '0) phase <= PH_IDLE;
                 else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign ras_low_o   = (phase == PH_ACT);
  assign cas_low_o   = !ro_q && (phase == PH_LEAD || phase == PH_ACT);
  assign act_first_o = (phase == PH_ACT) && (cnt == RAS_LD);
  assign done_o      = (phase == PH_PRE) && (cnt == '0);
  assign idle_o      = (phase == PH_IDLE);

  AST_CAS_LEADS_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_first_o && !ro_q) |-> $past(cas_low_o)); // R4

endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr import dram_rfsh_pkg::*; #(
  parameter int unsigned ROWS = 512
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    adv_i,
  output logic [$clog2(ROWS)-1:0] row_o
);
  localparam int unsigned RW = $clog2(ROWS);
  localparam logic [RW-1:0] TOP = RW'(ROWS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_o <= '0;
    else if (adv_i) row_o <= RW'(wrap_inc(int'(row_o), ROWS));
  end

  AST_ROW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && row_o == TOP) |=> (row_o == '0)); // R5

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq import dram_rfsh_pkg::*; #(
  parameter int unsigned TICK_HZ   = 1000000,
  parameter int unsigned WINDOW_US = 8200,
  parameter int unsigned SR_MIN_US = 100,
  parameter int unsigned ROWS      = 512,
  parameter int unsigned LEAD_CLKS = 1,
  parameter int unsigned RAS_CLKS  = 2,
  parameter int unsigned PRE_CLKS  = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    ras_only_mode_i,
  input  logic                    rw_req_i,
  input  logic                    sr_enter_i,
  input  logic                    sr_exit_i,
  input  logic                    abort_i,
  output logic                    rw_gnt_o,
  output logic                    ras_n_o,
  output logic                    cas_n_o,
  output logic [$clog2(ROWS)-1:0] row_o,
  output logic                    win_err_o
);
  localparam int unsigned RW        = $clog2(ROWS);
  localparam int unsigned WIN_TICKS = us_to_ticks(TICK_HZ, WINDOW_US);
  localparam int unsigned SR_TICKS  = us_to_ticks(TICK_HZ, SR_MIN_US);
  localparam logic [RW-1:0] LAST    = RW'(ROWS - 1);

  seq_state_t    state;
  logic [RW-1:0] burst_cnt;
  logic abort_pend, exit_pend, win_run, sr_ras, sr_cas, win_err;

  // Named internal events
  logic cyc_ras_low, cyc_cas_low, cyc_act_first, cyc_done, cyc_idle;
  logic burst_state, cyc_start, last_cycle, first_fall, final_fall;
  logic abort_now, hold_met, win_hit, sr_release, row_adv;

  assign burst_state = (state == ST_PRE_BURST) || (state == ST_POST_BURST);
  assign cyc_start   = burst_state && cyc_idle;
  assign last_cycle  = (burst_cnt == LAST);
  assign first_fall  = cyc_act_first && (state == ST_PRE_BURST) && (burst_cnt == '0);
  assign final_fall  = cyc_act_first && (state == ST_POST_BURST) && last_cycle;
  assign abort_now   = abort_pend || abort_i;
  assign sr_release  = (state == ST_SR_HOLD) && hold_met && exit_pend;
  assign row_adv     = cyc_done && ras_only_mode_i;

  rfsh_cycle_gen #(.LEAD_CLKS(LEAD_CLKS), .RAS_CLKS(RAS_CLKS), .PRE_CLKS(PRE_CLKS)) u_cyc (
    .clk_i, .rst_ni, .start_i(cyc_start), .ras_only_i(ras_only_mode_i),
    .ras_low_o(cyc_ras_low), .cas_low_o(cyc_cas_low), .act_first_o(cyc_act_first),
    .done_o(cyc_done), .idle_o(cyc_idle));

  rfsh_row_ctr #(.ROWS(ROWS)) u_row (
    .clk_i, .rst_ni, .adv_i(row_adv), .row_o(row_o));

  rfsh_tick_timer #(.LIMIT(WIN_TICKS)) u_win (
    .clk_i, .rst_ni, .run_i(win_run), .tick_i, .reached_o(win_hit));

  rfsh_tick_timer #(.LIMIT(SR_TICKS)) u_hold (
    .clk_i, .rst_ni, .run_i(state == ST_SR_HOLD), .tick_i, .reached_o(hold_met));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      burst_cnt  <= '0;
      abort_pend <= 1'b0;
      exit_pend  <= 1'b0;
      win_run    <= 1'b0;
      sr_ras     <= 1'b0;
      sr_cas     <= 1'b0;
      win_err    <= 1'b0;
    end else begin
      if (win_run && win_hit) win_err <= 1'b1;
      case (state)
        ST_IDLE: if (sr_enter_i) begin
          state      <= ST_PRE_BURST;
          burst_cnt  <= '0;
          abort_pend <= 1'b0;
        end
        ST_PRE_BURST, ST_POST_BURST: begin
          if (abort_i)    abort_pend <= 1'b1;
          if (first_fall) win_run    <= 1'b1;
          if (final_fall) win_run    <= 1'b0;
          if (cyc_done) begin
            if (abort_now) begin
              state      <= ST_IDLE;
              abort_pend <= 1'b0;
              win_run    <= 1'b0;
              burst_cnt  <= '0;
            end else if (last_cycle) begin
              burst_cnt <= '0;
              if (state == ST_PRE_BURST) begin
                state  <= ST_SR_LEAD;
                sr_cas <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              burst_cnt <= burst_cnt + 1'b1;
            end
          end
        end
        ST_SR_LEAD: begin
          state     <= ST_SR_HOLD;
          sr_ras    <= 1'b1;
          win_run   <= 1'b0;
          exit_pend <= sr_exit_i;
        end
        ST_SR_HOLD: begin
          if (sr_exit_i) exit_pend <= 1'b1;
          if (sr_release) begin
            sr_ras    <= 1'b0;
            sr_cas    <= 1'b0;
            exit_pend <= 1'b0;
            win_run   <= 1'b1;
            state     <= ST_POST_BURST;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rw_gnt_o  = (state == ST_IDLE) && rw_req_i && !sr_enter_i;
  assign ras_n_o   = !(cyc_ras_low || sr_ras);
  assign cas_n_o   = !(cyc_cas_low || sr_cas);
  assign win_err_o = win_err;

  AST_GNT_PINS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_gnt_o |-> (ras_n_o && cas_n_o)); // R2
  AST_RASONLY_CAS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_only_mode_i && burst_state && !ras_n_o) |-> cas_n_o); // R5
  AST_ROW_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && $past(!ras_n_o)) |-> $stable(row_o)); // R5
  AST_SR_MIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ras_n_o) && $past(state) == ST_SR_HOLD) |-> $past(hold_met)); // R6
  AST_SR_SINGLE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sr_ras && !cyc_idle)); // R6
  AST_EXIT_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ras_n_o) && $past(state) == ST_SR_HOLD) |-> cas_n_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_err_o |=> win_err_o); // R8

endmodule

// File: tb/dram_rfsh_seq_tb_top.sv
module dram_rfsh_seq_tb_top;
  localparam int ROWS     = 512;
  localparam int RAS_CLKS = 2;
  localparam int TICK_DIV = 4;
  localparam int SR_TICKS = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic mode = 1'b0, req = 1'b0, sr_en = 1'b0, sr_ex = 1'b0, abrt = 1'b0;
  logic gnt, ras_n, cas_n, err;
  logic [8:0] row;
  logic gnt_e, ras_e, cas_e, err_e;
  logic [8:0] row_e;

  int vectors = 0;
  int fails = 0;
  int exp_row = 0;
  int tdiv = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    tick <= (tdiv == 0);
  end

  dram_rfsh_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ras_only_mode_i(mode),
    .rw_req_i(req), .sr_enter_i(sr_en), .sr_exit_i(sr_ex), .abort_i(abrt),
    .rw_gnt_o(gnt), .ras_n_o(ras_n), .cas_n_o(cas_n), .row_o(row), .win_err_o(err));

  dram_rfsh_seq #(.WINDOW_US(100)) dut_err_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ras_only_mode_i(mode),
    .rw_req_i(req), .sr_enter_i(sr_en), .sr_exit_i(sr_ex), .abort_i(abrt),
    .rw_gnt_o(gnt_e), .ras_n_o(ras_e), .cas_n_o(cas_e), .row_o(row_e), .win_err_o(err_e));

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Counts refresh pulses until self-refresh is seen or the pins go quiet.
  task automatic run_burst(input bit ras_only, input bit want_sr, input string tag);
    int pulses = 0, bad_cas = 0, bad_row = 0, bad_w = 0, gnt_hi = 0, quiet = 0;
    bit sr_seen = 0;
    bit prev_cas = cas_n;
    while (!sr_seen && quiet < 12) begin
      step();
      if (gnt && pulses < ROWS) gnt_hi++;
      if (ras_n == 1'b0) begin
        bit cas_before = prev_cas;
        bit cas_at = cas_n;
        int r_at = int'(row);
        int len = 1;
        bit moved = 0;
        quiet = 0;
        while (ras_n == 1'b0 && len <= RAS_CLKS + 2) begin
          step();
          if (gnt) gnt_hi++;
          if (ras_n == 1'b0) begin
            len++;
            if (int'(row) != r_at) moved = 1;
          end
        end
        if (len > RAS_CLKS + 2) begin
          sr_seen = 1;
          check(cas_before == 1'b0, "R6", {tag, " cas before self-refresh fall"}, cas_before, 0);
        end else begin
          pulses++;
          if (len != RAS_CLKS) bad_w++;
          if (ras_only) begin
            if (cas_at != 1'b1 || cas_before != 1'b1) bad_cas++;
            if (r_at != exp_row || moved) bad_row++;
            exp_row = (exp_row + 1) % ROWS;
          end else begin
            if (cas_at != 1'b0 || cas_before != 1'b0) bad_cas++;
            if (r_at != 0) bad_row++;
          end
        end
      end else begin
        quiet++;
      end
      prev_cas = cas_n;
    end
    check(pulses == ROWS, "R3", {tag, " pulse count"}, pulses, ROWS);
    check(bad_w == 0, "R3", {tag, " pulse width errors"}, bad_w, 0);
    check(bad_cas == 0, ras_only ? "R5" : "R4", {tag, " cas ordering errors"}, bad_cas, 0);
    check(bad_row == 0, "R5", {tag, " row sequence errors"}, bad_row, 0);
    check(gnt_hi == 0, "R2", {tag, " grant during burst"}, gnt_hi, 0);
    check(sr_seen == want_sr, "R6", {tag, " self-refresh seen"}, sr_seen, want_sr);
  endtask

  task automatic t_reset();
    check(ras_n == 1'b1, "R1", "ras_n after reset", ras_n, 1);
    check(cas_n == 1'b1, "R1", "cas_n after reset", cas_n, 1);
    check(row == 9'd0, "R1", "row after reset", row, 0);
    check(err == 1'b0, "R1", "err after reset", err, 0);
  endtask

  task automatic t_grant();
    req = 1'b1; #1;
    check(gnt == 1'b1, "R2", "grant when idle", gnt, 1);
    step();
    req = 1'b0; #1;
    check(gnt == 1'b0, "R2", "grant without request", gnt, 0);
    step();
  endtask

  task automatic t_self_refresh(input bit ras_only, input string tag);
    int len;
    int exp_start = exp_row;
    mode = ras_only;
    req = 1'b1;
    step();
    sr_en = 1'b1; #1;
    check(gnt == 1'b0, "R2", {tag, " grant with same-cycle enter"}, gnt, 0);
    step();
    sr_en = 1'b0;
    run_burst(ras_only, 1'b1, {tag, " pre"});
    check(err == 1'b0, "R8", {tag, " no error inside window"}, err, 0);
    check(err_e == 1'b1, "R8", {tag, " short window flags error"}, err_e, 1);
    check(cas_n == 1'b0, "R6", {tag, " cas low in self-refresh"}, cas_n, 0);
    len = RAS_CLKS + 3;
    sr_ex = 1'b1;
    step();
    sr_ex = 1'b0;
    if (ras_n == 1'b0) len++;
    while (ras_n == 1'b0 && len < 5000) begin
      step();
      if (ras_n == 1'b0) len++;
    end
    check(len >= (SR_TICKS - 1) * TICK_DIV, "R6", {tag, " self-refresh min hold clocks"}, len, (SR_TICKS - 1) * TICK_DIV);
    check(len <= SR_TICKS * TICK_DIV + 4, "R7", {tag, " prompt release"}, len, SR_TICKS * TICK_DIV + 4);
    check(cas_n == 1'b1, "R7", {tag, " cas rises with ras"}, cas_n, 1);
    run_burst(ras_only, 1'b0, {tag, " post"});
    check(gnt == 1'b1, "R2", {tag, " grant returns"}, gnt, 1);
    check(int'(row) == exp_start, "R5", {tag, " row after two bursts"}, row, exp_start);
    check(err == 1'b0, "R8", {tag, " no error after exit"}, err, 0);
    check(err_e == 1'b1, "R8", {tag, " error sticky"}, err_e, 1);
  endtask

  task automatic t_abort();
    int falls = 0, len = 0, extra = 0;
    bit prev = 1'b1;
    mode = 1'b0;
    req = 1'b1;
    abrt = 1'b1;
    step();
    abrt = 1'b0; #1;
    check(gnt == 1'b1, "R9", "abort in idle keeps grant", gnt, 1);
    sr_en = 1'b1;
    step();
    sr_en = 1'b0;
    while (falls < 3 && len < 200) begin
      step();
      len++;
      if (prev && !ras_n) falls++;
      prev = ras_n;
    end
    check(falls == 3, "R9", "burst starts after idle abort", falls, 3);
    abrt = 1'b1;
    len = 1;
    step();
    abrt = 1'b0;
    while (ras_n == 1'b0 && len < 20) begin
      len++;
      step();
    end
    check(len == RAS_CLKS, "R9", "aborted pulse full width", len, RAS_CLKS);
    prev = ras_n;
    for (int i = 0; i < 30; i++) begin
      step();
      if (prev && !ras_n) extra++;
      prev = ras_n;
    end
    check(extra == 0, "R9", "no pulse after abort", extra, 0);
    check(gnt == 1'b1, "R9", "grant after abort", gnt, 1);
    req = 1'b0;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_grant();
    t_self_refresh(1'b0, "cbr");
    t_self_refresh(1'b1, "rasonly");
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule